// File: doc/BRIEF.md
# Wavefront Slot Scheduler with Register Admission

This block sits beside one SIMD and manages the wavefronts that live on it. A launcher offers a wavefront with a per-lane vector register count and a width flag (32 or 64 lanes). The block admits it only when two things are true: a wave slot is free, and a contiguous run of register granules large enough for the wave is free. An admitted wave gets a slot number and a register base. When the wave finishes, its slot and its register run are returned.

Each cycle the block also picks one resident wave to issue. It looks at every slot's ready input and rotates fairly through the candidates. Fetch, decode and execution live elsewhere and appear here only as per-slot ready and done inputs. Because admission is limited by register space as well as by slots, heavy kernels reach fewer resident waves than light ones.

Top module: `wave_slot_sched`

## Requirements
- R1: After reset no slot is resident, `issueValid` is low and `launchReady` is high for any request.
- R2: At most 16 wavefronts are resident. With all 16 slots busy, `launchReady` stays low even when registers are free.
- R3: Register space is 64 granules of 16 wave32 registers (1024 in all). A wave needs ceil(count/16) granules, at least one, so 16 waves of 64 registers each fill the file exactly.
- R4: Waves of 96 registers at 32 lanes take 6 granules each. Ten are admitted and the eleventh is held.
- R5: A 64-lane wave (`launchWide`=1) needs twice the granules of a 32-lane wave with the same count. Four 128-register wide waves are admitted and a fifth is held.
- R6: A grant goes to the lowest-numbered free slot. Its register run starts at the lowest granule where the whole run is free, and `grantBase` is that granule times 16. If free space exists but no run is long enough, the request is held.
- R7: A `waveDone` pulse on a resident slot frees its slot and its registers at the next clock edge. A launch in the same cycle cannot use them; in the following cycle it can.
- R8: A `waveDone` bit for an empty slot has no effect on slots or registers.
- R9: `issueValid` is high when some resident slot has its ready bit set. `issueSlot` is the first such slot after the last issued slot, wrapping around; the search starts at slot 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | A launch request is offered |
| launchRegs | input | 9 | Vector registers per lane for the request |
| launchWide | input | 1 | 1 = 64-lane wave, 0 = 32-lane wave |
| launchReady | output | 1 | Request can be admitted this cycle |
| grantSlot | output | 4 | Slot given to the request when admitted |
| grantBase | output | 10 | First wave32 register of the granted run |
| waveReady | input | 16 | Per-slot ready-to-issue flag |
| waveDone | input | 16 | Per-slot completion pulse |
| issueValid | output | 1 | A wave is picked this cycle |
| issueSlot | output | 4 | Slot picked for issue |

## Verification
Directed runs fill the file with light waves, so the slot limit binds first. Further runs use 64-register, 96-register and wide waves, so the register limit binds at 16, 10 and 4 waves. A fragmented run frees two separate gaps and shows that total free space is not enough without a contiguous run. A done in the same cycle as a blocked launch separates the one-cycle reuse delay from an immediate one, and done pulses on empty slots show that nothing is freed twice. A long random mix of launches, completions and ready masks is compared against a bench model of slots, granules and the rotating issue pointer.

// File: rtl/wave_sched_pkg.sv
package wave_sched_pkg;
  localparam int unsigned NumSlots  = 16;
  localparam int unsigned SlotW     = $clog2(NumSlots);
  localparam int unsigned BlockRegs = 16;
  localparam int unsigned GranShift = $clog2(BlockRegs);
  localparam int unsigned NumBlocks = 64;
  localparam int unsigned BlockW    = $clog2(NumBlocks);
  localparam int unsigned NeedW     = BlockW + 1;
  localparam int unsigned RegCntW   = 9;
  localparam int unsigned BaseW     = $clog2(NumBlocks * BlockRegs);

  typedef logic [SlotW-1:0]     slotIdx_t;
  typedef logic [NumSlots-1:0]  slotMask_t;
  typedef logic [NumBlocks-1:0] blockMask_t;

  typedef struct packed {
    logic      allocEn;
    slotIdx_t  allocSlot;
    slotMask_t freeMask;
  } strobes_t;
endpackage

// File: rtl/wave_reg_alloc.sv
module wave_reg_alloc
  import wave_sched_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [RegCntW-1:0] launchRegs,
  input  logic               launchWide,
  output logic               fitFound,
  output logic [BlockW-1:0]  fitStart,
  output blockMask_t         usedBlocks
);
  function automatic blockMask_t spanMask(input logic [NeedW-1:0] n);
    return (blockMask_t'(1) << n) - blockMask_t'(1);
  endfunction

  logic [RegCntW:0]  roundedSum;
  logic [NeedW-1:0]  granNarrow;
  logic [NeedW-1:0]  need;
  blockMask_t        needMask;
  blockMask_t        allocMask;
  blockMask_t        freeBits;
  logic [BlockW-1:0] slotBase [NumSlots];
  logic [NeedW-1:0]  slotNeed [NumSlots];
  blockMask_t        slotSpan [NumSlots];

  always_comb begin
    roundedSum = {1'b0, launchRegs} + (RegCntW+1)'(BlockRegs - 1);
    granNarrow = NeedW'(roundedSum >> GranShift);
    if (granNarrow == '0) granNarrow = NeedW'(1);
    need     = launchWide ? NeedW'(granNarrow << 1) : granNarrow;
    needMask = spanMask(need);
  end

  // first fit: scan downward so the lowest start wins
  always_comb begin
    fitFound = 1'b0;
    fitStart = '0;
    for (int s = NumBlocks - 1; s >= 0; s--) begin
      if ((s + int'(need) <= int'(NumBlocks)) &&
          ((usedBlocks & (needMask << s)) == '0)) begin
        fitFound = 1'b1;
        fitStart = BlockW'(s);
      end
    end
    allocMask = strb.allocEn ? (needMask << fitStart) : '0;
  end

  for (genvar g = 0; g < NumSlots; g++) begin : g_span
    assign slotSpan[g] = strb.freeMask[g] ? (spanMask(slotNeed[g]) << slotBase[g]) : '0;
  end

  always_comb begin
    freeBits = '0;
    for (int i = 0; i < NumSlots; i++) freeBits = freeBits | slotSpan[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedBlocks <= '0;
      for (int i = 0; i < NumSlots; i++) begin
        slotBase[i] <= '0;
        slotNeed[i] <= '0;
      end
    end else begin
      usedBlocks <= (usedBlocks & ~freeBits) | allocMask;
      if (strb.allocEn) begin
        slotBase[strb.allocSlot] <= fitStart;
        slotNeed[strb.allocSlot] <= need;
      end
    end
  end

  // R6
  no_double_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |-> ((usedBlocks & allocMask) == '0));

  // R7
  freed_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.freeMask != '0 && !strb.allocEn) |=> ((usedBlocks & $past(freeBits)) == '0));
endmodule

// File: rtl/wave_slot_ctrl.sv
module wave_slot_ctrl
  import wave_sched_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      launchValid,
  input  logic      fitFound,
  input  slotMask_t waveReady,
  input  slotMask_t waveDone,
  output logic      launchReady,
  output slotIdx_t  grantSlot,
  output logic      issueValid,
  output slotIdx_t  issueSlot,
  output strobes_t  strb,
  output slotMask_t busy
);
  logic      anyFree;
  logic      accept;
  slotMask_t cand;
  slotIdx_t  lastIssued;
  slotIdx_t  probe;

  always_comb begin
    anyFree   = 1'b0;
    grantSlot = '0;
    for (int i = NumSlots - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        anyFree   = 1'b1;
        grantSlot = SlotW'(i);
      end
    end
    launchReady = anyFree && fitFound;
    accept      = launchValid && launchReady;
    strb.allocEn   = accept;
    strb.allocSlot = grantSlot;
    strb.freeMask  = waveDone & busy;
  end

  always_comb begin
    cand       = busy & waveReady;
    issueValid = 1'b0;
    issueSlot  = '0;
    probe      = '0;
    for (int k = 1; k <= NumSlots; k++) begin
      probe = SlotW'((int'(lastIssued) + k) % NumSlots);
      if (!issueValid && cand[probe]) begin
        issueValid = 1'b1;
        issueSlot  = probe;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= '0;
      lastIssued <= SlotW'(NumSlots - 1);
    end else begin
      busy <= (busy & ~strb.freeMask) | (accept ? (slotMask_t'(1) << grantSlot) : '0);
      if (issueValid) lastIssued <= issueSlot;
    end
  end

  // R2
  slot_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&busy) |-> !launchReady);

  // R9
  issue_rotates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && $past(issueValid) && $countones(busy & waveReady) > 1)
      |-> (issueSlot != $past(issueSlot)));
endmodule

// File: rtl/wave_slot_sched.sv
module wave_slot_sched
  import wave_sched_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               launchValid,
  input  logic [RegCntW-1:0] launchRegs,
  input  logic               launchWide,
  output logic               launchReady,
  output logic [SlotW-1:0]   grantSlot,
  output logic [BaseW-1:0]   grantBase,
  input  logic [NumSlots-1:0] waveReady,
  input  logic [NumSlots-1:0] waveDone,
  output logic               issueValid,
  output logic [SlotW-1:0]   issueSlot
);
  strobes_t          strb;
  slotMask_t         busy;
  logic              fitFound;
  logic [BlockW-1:0] fitStart;
  blockMask_t        usedBlocks;

  wave_slot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .launchValid(launchValid), .fitFound(fitFound),
    .waveReady(waveReady), .waveDone(waveDone), .launchReady(launchReady),
    .grantSlot(grantSlot), .issueValid(issueValid), .issueSlot(issueSlot),
    .strb(strb), .busy(busy)
  );

  wave_reg_alloc u_alloc (
    .clk(clk), .rstN(rstN), .strb(strb), .launchRegs(launchRegs),
    .launchWide(launchWide), .fitFound(fitFound), .fitStart(fitStart),
    .usedBlocks(usedBlocks)
  );

  assign grantBase = BaseW'(fitStart) << GranShift;

  // R3
  block_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(usedBlocks) >= $countones(busy));

  // R6
  grant_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(launchValid && launchReady) |-> busy[$past(grantSlot)]);
endmodule

// File: tb/test_wave_slot_sched.sv
module test_wave_slot_sched;
  localparam int Slots = 16;
  localparam int Blocks = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        launchValid = 1'b0;
  logic [8:0]  launchRegs = '0;
  logic        launchWide = 1'b0;
  logic        launchReady;
  logic [3:0]  grantSlot;
  logic [9:0]  grantBase;
  logic [15:0] waveReady = '0;
  logic [15:0] waveDone = '0;
  logic        issueValid;
  logic [3:0]  issueSlot;

  int checks = 0;
  int fails = 0;

  bit mBusy [Slots];
  int mBase [Slots];
  int mSize [Slots];
  bit mUsed [Blocks];
  int mLast = Slots - 1;

  always #4 clk = ~clk;

  wave_slot_sched i_wave_slot_sched (
    .clk(clk), .rstN(rstN), .launchValid(launchValid), .launchRegs(launchRegs),
    .launchWide(launchWide), .launchReady(launchReady), .grantSlot(grantSlot),
    .grantBase(grantBase), .waveReady(waveReady), .waveDone(waveDone),
    .issueValid(issueValid), .issueSlot(issueSlot)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int needOf(int regs, bit wide);
    int n = (regs + 15) / 16;
    if (n == 0) n = 1;
    if (wide) n = n * 2;
    return n;
  endfunction

  function automatic int fitOf(int n);
    for (int s = 0; s + n <= Blocks; s++) begin
      bit ok = 1'b1;
      for (int b = s; b < s + n; b++) if (mUsed[b]) ok = 1'b0;
      if (ok) return s;
    end
    return -1;
  endfunction

  function automatic int freeSlotOf();
    for (int i = 0; i < Slots; i++) if (!mBusy[i]) return i;
    return -1;
  endfunction

  function automatic int pickOf(logic [15:0] rdy);
    for (int k = 1; k <= Slots; k++) begin
      int idx = (mLast + k) % Slots;
      if (mBusy[idx] && rdy[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < Slots; i++) begin mBusy[i] = 0; mBase[i] = 0; mSize[i] = 0; end
    for (int b = 0; b < Blocks; b++) mUsed[b] = 0;
    mLast = Slots - 1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; launchValid = 1'b0; waveReady = '0; waveDone = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelClear();
  endtask

  task automatic step(string tag, bit lv, int regs, bit wide, logic [15:0] rdy, logic [15:0] dn);
    int n, fit, fs, pick;
    bit expRdy;
    @(negedge clk);
    launchValid = lv; launchRegs = 9'(regs); launchWide = wide;
    waveReady = rdy; waveDone = dn;
    #2;
    n = needOf(regs, wide);
    fit = fitOf(n);
    fs = freeSlotOf();
    expRdy = (fit >= 0) && (fs >= 0);
    pick = pickOf(rdy);
    chk(tag, "launchReady", int'(launchReady), int'(expRdy));
    if (expRdy) begin
      chk("R6", "grantSlot", int'(grantSlot), fs);
      chk("R6", "grantBase", int'(grantBase), fit * 16);
    end
    chk("R9", "issueValid", int'(issueValid), int'(pick >= 0));
    if (pick >= 0) chk("R9", "issueSlot", int'(issueSlot), pick);
    @(posedge clk);
    for (int i = 0; i < Slots; i++) begin
      if (dn[i] && mBusy[i]) begin
        mBusy[i] = 0;
        for (int b = mBase[i]; b < mBase[i] + mSize[i]; b++) mUsed[b] = 0;
      end
    end
    if (lv && expRdy) begin
      mBusy[fs] = 1; mBase[fs] = fit; mSize[fs] = n;
      for (int b = fit; b < fit + n; b++) mUsed[b] = 1;
    end
    if (pick >= 0) mLast = pick;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17C0DE));
    modelClear();
    // R1: reset state
    doReset();
    step("R1", 0, 64, 0, 16'hFFFF, '0);
    // R2: sixteen one-granule waves, then slot limit
    for (int i = 0; i < Slots; i++) step("R2", 1, 1, 0, '0, '0);
    step("R2", 1, 1, 0, '0, '0);
    // R9: rotation under full and sparse ready masks
    for (int i = 0; i < 20; i++) step("R9", 0, 1, 0, 16'hFFFF, '0);
    for (int i = 0; i < 8; i++) step("R9", 0, 1, 0, 16'h8421, '0);
    step("R9", 0, 1, 0, 16'h0000, '0);
    // R7: done and blocked launch in the same cycle, then reuse
    step("R7", 1, 1, 0, '0, 16'h0020);
    step("R7", 1, 1, 0, '0, '0);
    // R8: done on empty slots
    doReset();
    for (int i = 0; i < 4; i++) step("R8", 1, 16, 0, '0, '0);
    step("R8", 0, 16, 0, '0, 16'hFF00);
    step("R8", 1, 16, 0, '0, '0);
    // R3 and R6: full register file, then fragmentation
    doReset();
    for (int i = 0; i < Slots; i++) step("R3", 1, 64, 0, '0, '0);
    step("R3", 0, 64, 0, '0, 16'h000A);
    step("R6", 1, 128, 0, '0, '0);
    step("R6", 1, 64, 0, '0, '0);
    // R4: 96-register waves
    doReset();
    for (int i = 0; i < 11; i++) step("R4", 1, 96, 0, '0, '0);
    // R5: wide waves
    doReset();
    for (int i = 0; i < 5; i++) step("R5", 1, 128, 1, '0, '0);
    doReset();
    step("R5", 1, 511, 1, '0, '0);
    step("R5", 1, 1, 0, '0, '0);
    // random mix against the model
    doReset();
    for (int c = 0; c < 4000; c++) begin
      logic [15:0] dn = '0;
      for (int i = 0; i < Slots; i++) if ($urandom_range(0, 9) == 0) dn[i] = 1'b1;
      step("R3", 1'($urandom_range(0, 1)), int'($urandom_range(0, 160)),
           1'($urandom_range(0, 3) == 0), 16'($urandom), dn);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule